// File: doc/BRIEF.md
# SPI Receive Data Match Filter

This block sits in the receive path of an SPI slave, between the deserializer and the receive storage. Each received word comes with a valid strobe and a discard indication. The block compares each kept word with programmed match values. In pair mode a word matches if it equals either of two match words. In masked mode a word matches if it equals the first match word on the bits that a mask selects. A match sets a sticky flag, which software clears with a one-cycle pulse.

Matching can be limited to the first word, or to the first two words, after a start-of-frame pulse. Discarded words never match, are never forwarded and are not counted, so the first word of a frame is the first word that is kept. A match-only option drops every word until a match occurs. The matching word is forwarded, and so is everything after it while the flag stays set. To resume normal reception, software clears match-only mode first and then clears the flag. Data keeps flowing through both steps.

Forwarded words leave the block one clock after they arrive. The flag rises in that same clock.

Top module: `spi_rx_match_filter`

## Requirements
- R1: With `cfg_mode`=0 (pair mode), a kept word inside the match window is a hit when it equals `match0` or `match1`.
- R2: With `cfg_mode`=1 (masked mode), a kept word inside the window is a hit when `(rx_data & mask) == (match0 & mask)`. A mask bit of 1 means that bit is compared. `match1` has no effect in this mode.
- R3: `cfg_window` selects the match window. 0 means every word. 1 means only the first kept word since `frame_start`. 2 means the first two kept words. 3 behaves as 0. A word that arrives in the same cycle as `frame_start` is the first word of the new frame.
- R4: A word that arrives with `rx_discard`=1 never sets the flag and is never forwarded. It does not advance the window count, so the first-word comparison waits for the first kept word.
- R5: `match_flag` rises in the cycle after a hit. It stays set until a `flag_clr` pulse clears it. A hit in the same cycle as `flag_clr` leaves the flag set.
- R6: With `match_only`=0, every kept word appears on `fwd_data` with `fwd_valid`=1 one cycle after it arrives. `fwd_data` holds its value when nothing is forwarded.
- R7: With `match_only`=1 and the flag clear, a kept word that is not a hit is dropped and a hit word is forwarded. With the flag set, kept words are forwarded.
- R8: Clearing `match_only` and then pulsing `flag_clr` keeps every kept word forwarded through both steps.
- R9: After reset, `match_flag`, `fwd_valid` and `fwd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_data | input | W | Received word |
| rx_discard | input | 1 | This word is dropped by the receive mask control |
| frame_start | input | 1 | Start-of-frame pulse; restarts the window count |
| cfg_mode | input | 1 | 0 = pair mode, 1 = masked mode |
| cfg_window | input | 2 | Match window select (see R3) |
| match_only | input | 1 | Drop kept words until a match |
| match0 | input | W | First match word |
| match1 | input | W | Second match word (pair mode only) |
| mask | input | W | Compare mask for masked mode |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| fwd_valid | output | 1 | Forwarded word is valid |
| fwd_data | output | W | Forwarded word |
| match_flag | output | 1 | Sticky match flag |

## Verification
The assertions assume that the configuration inputs, `match0`, `match1` and `mask` change only between words. They also assume that `rx_discard` is meaningful only while `rx_valid` is high. The bench meets both assumptions. It rewrites the configuration only in cycles with no word on the input, and it drives `rx_discard` together with `rx_valid`. Random data is drawn partly from the programmed match words and from near misses that differ from them in one bit, so that hits, misses, window edges and clears that collide with a hit all occur often.

// File: rtl/spi_rxm_pkg.sv
package spi_rxm_pkg;
  typedef enum logic {
    MODE_PAIR   = 1'b0,
    MODE_MASKED = 1'b1
  } rxm_mode_e;

  typedef enum logic [1:0] {
    WIN_ALL    = 2'd0,
    WIN_FIRST1 = 2'd1,
    WIN_FIRST2 = 2'd2,
    WIN_ALT    = 2'd3
  } rxm_win_e;
endpackage

// File: rtl/spi_rxm_cmp.sv
module spi_rxm_cmp
  import spi_rxm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] m0,
  input  logic [W-1:0] m1,
  input  logic [W-1:0] mask,
  input  rxm_mode_e    mode,
  output logic         hit
);
  logic [W-1:0] eq0, eq1, eqm;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eq0[i] = (word[i] == m0[i]);
    assign eq1[i] = (word[i] == m1[i]);
    assign eqm[i] = eq0[i] | ~mask[i];
  end

  always_comb begin
    if (mode == MODE_MASKED) hit = &eqm;
    else                     hit = (&eq0) | (&eq1);
  end
endmodule

// File: rtl/spi_rxm_window.sv
module spi_rxm_window
  import spi_rxm_pkg::*;
#(
  parameter int CNT_SAT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_start,
  input  logic     word_kept,
  input  rxm_win_e win_sel,
  output logic     in_window
);
  localparam int CNT_W = $clog2(CNT_SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(CNT_SAT);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic             cnt_en;

  always_comb begin
    cnt_eff = frame_start ? '0 : cnt_q;
    cnt_en  = word_kept | frame_start;
    cnt_d   = cnt_eff;
    if (word_kept && (cnt_eff != SAT_V)) cnt_d = cnt_eff + 1'b1;
  end

  always_comb begin
    unique case (win_sel)
      WIN_FIRST1: in_window = (cnt_eff == '0);
      WIN_FIRST2: in_window = (cnt_eff < CNT_W'(2));
      default:    in_window = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rxm_gate.sv
module spi_rxm_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_kept,
  input  logic         hit,
  input  logic [W-1:0] word,
  input  logic         match_only,
  input  logic         flag_clr,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data,
  output logic         match_flag
);
  logic         flag_d, fwd_d, data_en;

  always_comb begin
    flag_d  = hit | (match_flag & ~flag_clr);
    fwd_d   = word_kept & (~match_only | match_flag | hit);
    data_en = fwd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      fwd_valid  <= 1'b0;
    end else begin
      match_flag <= flag_d;
      fwd_valid  <= fwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fwd_data <= '0;
    else if (data_en) fwd_data <= word;
  end
endmodule

// File: rtl/spi_rx_match_filter.sv
module spi_rx_match_filter
  import spi_rxm_pkg::*;
#(
  parameter int W       = 16,
  parameter int CNT_SAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_discard,
  input  logic         frame_start,
  input  logic         cfg_mode,
  input  logic [1:0]   cfg_window,
  input  logic         match_only,
  input  logic [W-1:0] match0,
  input  logic [W-1:0] match1,
  input  logic [W-1:0] mask,
  input  logic         flag_clr,
  output logic         fwd_valid,
  output logic [W-1:0] fwd_data,
  output logic         match_flag
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       word_kept, cmp_hit, in_window, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign word_kept = rx_valid & ~rx_discard;
  assign hit       = word_kept & in_window & cmp_hit;

  spi_rxm_cmp #(.W(W)) cmp_i (
    .word (rx_data),
    .m0   (match0),
    .m1   (match1),
    .mask (mask),
    .mode (rxm_mode_e'(cfg_mode)),
    .hit  (cmp_hit)
  );

  spi_rxm_window #(.CNT_SAT(CNT_SAT)) win_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .word_kept   (word_kept),
    .win_sel     (rxm_win_e'(cfg_window)),
    .in_window   (in_window)
  );

  spi_rxm_gate #(.W(W)) gate_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .word_kept  (word_kept),
    .hit        (hit),
    .word       (rx_data),
    .match_only (match_only),
    .flag_clr   (flag_clr),
    .fwd_valid  (fwd_valid),
    .fwd_data   (fwd_data),
    .match_flag (match_flag)
  );
endmodule

// File: rtl/spi_rx_match_filter_chk.sv
module spi_rx_match_filter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_int_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_discard,
  input logic         frame_start,
  input logic         cfg_mode,
  input logic [1:0]   cfg_window,
  input logic         match_only,
  input logic [W-1:0] match0,
  input logic [W-1:0] match1,
  input logic [W-1:0] mask,
  input logic         flag_clr,
  input logic         fwd_valid,
  input logic [W-1:0] fwd_data,
  input logic         match_flag
);
  logic kept;
  assign kept = rx_valid & ~rx_discard;

  // R1
  pair_hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    kept && !cfg_mode && (cfg_window == 2'd0) && (rx_data == match1) |=> match_flag);

  // R2
  masked_hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    kept && cfg_mode && (cfg_window == 2'd0) && ((rx_data & mask) == (match0 & mask)) |=> match_flag);

  // R3
  window_first_hit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    kept && frame_start && (cfg_window == 2'd1) && !cfg_mode && (rx_data == match0) |=> match_flag);

  // R4
  discard_no_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !match_flag && !kept |=> !match_flag);

  // R4
  discard_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !kept |=> !fwd_valid && $stable(fwd_data));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    match_flag && !flag_clr |=> match_flag);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    match_flag && flag_clr && !kept |=> !match_flag);

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    kept && !match_only |=> fwd_valid && (fwd_data == $past(rx_data)));

  // R7
  match_only_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    kept && match_only && !match_flag |=> (fwd_valid == match_flag));
endmodule

bind spi_rx_match_filter spi_rx_match_filter_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .rx_discard  (rx_discard),
  .frame_start (frame_start),
  .cfg_mode    (cfg_mode),
  .cfg_window  (cfg_window),
  .match_only  (match_only),
  .match0      (match0),
  .match1      (match1),
  .mask        (mask),
  .flag_clr    (flag_clr),
  .fwd_valid   (fwd_valid),
  .fwd_data    (fwd_data),
  .match_flag  (match_flag)
);

// File: tb/spi_rx_match_filter_tb.sv
module spi_rx_match_filter_tb_top;
  localparam int W = 16;

  logic         clk, rst_n;
  logic         rx_valid, rx_discard, frame_start, cfg_mode, match_only, flag_clr;
  logic [1:0]   cfg_window;
  logic [W-1:0] rx_data, match0, match1, mask;
  logic         fwd_valid, match_flag;
  logic [W-1:0] fwd_data;

  int n_chk = 0, n_fail = 0;
  logic         m_flag;
  int           m_cnt;
  logic [W-1:0] m_fd;

  spi_rx_match_filter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_discard(rx_discard), .frame_start(frame_start), .cfg_mode(cfg_mode),
    .cfg_window(cfg_window), .match_only(match_only), .match0(match0),
    .match1(match1), .mask(mask), .flag_clr(flag_clr), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .match_flag(match_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic ref_cmp(input logic [W-1:0] d);
    if (cfg_mode) return ((d & mask) == (match0 & mask));
    return (d == match0) || (d == match1);
  endfunction

  function automatic logic ref_win(input int cnt);
    case (cfg_window)
      2'd1:    return cnt == 0;
      2'd2:    return cnt < 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [W-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic dis, input logic [W-1:0] d,
                      input logic fs, input logic clr, input string tag);
    logic acc, hit, e_flag, e_fv;
    int   eff;
    rx_valid = v; rx_discard = dis; rx_data = d; frame_start = fs; flag_clr = clr;
    acc    = v && !dis;
    eff    = fs ? 0 : m_cnt;
    hit    = acc && ref_win(eff) && ref_cmp(d);
    e_flag = hit || (m_flag && !clr);
    e_fv   = acc && (!match_only || m_flag || hit);
    if (e_fv) m_fd = d;
    if (acc) m_cnt = (eff < 2) ? eff + 1 : 2;
    else     m_cnt = eff;
    m_flag = e_flag;
    @(posedge clk); #1;
    check(tag, "match_flag", W'(match_flag), W'(e_flag));
    check(tag, "fwd_valid", W'(fwd_valid), W'(e_fv));
    check(tag, "fwd_data", fwd_data, m_fd);
    @(negedge clk);
  endtask

  task automatic idle_cfg(input logic md, input logic [1:0] win, input logic mo);
    cfg_mode = md; cfg_window = win; match_only = mo;
  endtask

  initial begin
    #1500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rx_valid = 0; rx_discard = 0; frame_start = 0; flag_clr = 0;
    rx_data = '0; cfg_mode = 0; cfg_window = 0; match_only = 0;
    match0 = 16'hA5C3; match1 = 16'h1234; mask = 16'hFF00;
    m_flag = 0; m_cnt = 0; m_fd = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "match_flag", W'(match_flag), '0);
    check("R9", "fwd_valid", W'(fwd_valid), '0);
    check("R9", "fwd_data", fwd_data, '0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R6 pass-through, then R1 pair-mode hits on both words
    step(1, 0, 16'h0001, 1, 0, "R6");
    step(0, 0, 16'h0000, 0, 0, "R6");
    step(1, 0, 16'h1234, 0, 0, "R1");
    step(0, 0, 16'h0000, 0, 1, "R5");
    step(1, 0, 16'hA5C3, 0, 1, "R5");   // hit with clear: set wins
    step(0, 0, 16'h0000, 0, 1, "R5");
    // R2 masked mode: upper byte compared, match1 ignored
    idle_cfg(1, 0, 0);
    step(1, 0, 16'h1234, 0, 0, "R2");
    step(1, 0, 16'hA500, 0, 0, "R2");
    step(0, 0, 16'h0000, 0, 1, "R2");
    // R3 / R4 first-word window delayed by discarded words
    idle_cfg(0, 1, 0);
    step(1, 1, 16'hA5C3, 1, 0, "R4");
    step(1, 1, 16'h1234, 0, 0, "R4");
    step(1, 0, 16'hA5C3, 0, 0, "R3");
    step(0, 0, 16'h0000, 0, 1, "R3");
    step(1, 0, 16'hA5C3, 1, 0, "R3");
    step(1, 0, 16'hA5C3, 0, 1, "R3");   // second word, outside window 1
    idle_cfg(0, 2, 0);
    step(1, 0, 16'h0000, 1, 0, "R3");
    step(1, 0, 16'h1234, 0, 0, "R3");
    step(1, 0, 16'h1234, 0, 1, "R3");   // third word outside window 2
    step(0, 0, 16'h0000, 0, 0, "R3");
    // R7 match-only drop then forward; R8 resume order
    idle_cfg(0, 0, 1);
    step(1, 0, 16'h0F0F, 1, 0, "R7");
    step(1, 1, 16'hA5C3, 0, 0, "R7");
    step(1, 0, 16'hA5C3, 0, 0, "R7");
    step(1, 0, 16'h7777, 0, 0, "R7");
    idle_cfg(0, 0, 0);
    step(1, 0, 16'h6666, 0, 0, "R8");
    step(1, 0, 16'h5555, 0, 1, "R8");
    step(1, 0, 16'h4444, 0, 0, "R8");

    // randomized phase
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      int sel;
      if (i % 64 == 0) begin
        step(0, 0, 16'h0000, 0, 0, "R6");
        idle_cfg(1'($urandom), 2'($urandom), ($urandom % 3) == 0);
        match0 = 16'($urandom); match1 = 16'($urandom); mask = 16'($urandom);
      end
      sel = $urandom % 4;
      case (sel)
        0: d = match0;
        1: d = match1;
        2: d = match0 ^ (16'h1 << ($urandom % 16));
        default: d = 16'($urandom);
      endcase
      step(($urandom % 4) != 0, ($urandom % 5) == 0, d, ($urandom % 8) == 0,
           ($urandom % 12) == 0, cfg_mode ? "R2" : "R1");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule